// File: doc/BRIEF.md
# Double-Buffered Four-Channel Code Register Bank

This block stores conversion codes for four output channels. Each channel has two register levels: a staging register that takes every accepted write, and a live register whose contents drive the channel. A write beat carries a channel number, a 16-bit word and a hold flag. When the hold flag is set, only the staging register of the addressed channel changes. When it is clear, every channel whose staging register holds a value not yet passed on copies that value into its live register in the same cycle. A channel whose staging register has not been written since its last copy is left alone, so it never gets a redundant reload. Software can therefore stage several channels and then release all of them together with the final write.

Writes arrive on a valid/ready port. `wr_ready` is low while reset is asserted and during the first clock edge after release. From then on it stays high, so the bank never applies back-pressure. A beat is taken on every rising edge where both `wr_valid` and `wr_ready` are high. Beats offered while `wr_ready` is low are dropped, and the sender must keep them until ready rises. Each channel also decodes the top two bits of its live word into a one-hot drive mode. A one-cycle pulse marks every actual live-register load.

Top module: `dbuf_bank`

## Requirements
- R1: While `rst_n` is low, every live word is 0, every update pulse is 0, every channel mode reads normal (one-hot bit 0), and `wr_ready` is 0.
- R2: `wr_ready` rises at the first rising edge after `rst_n` goes high and stays high. A beat offered while `wr_ready` is low changes no output.
- R3: An accepted beat with `wr_hold`=1 loads only the staging register of channel `wr_chan`. No live word changes and no update pulse fires.
- R4: An accepted beat with `wr_hold`=0 copies every staging register that is pending into its live register. The new live words appear one clock after the accepting edge.
- R5: A channel whose staging register was not written since its last live load does not reload and does not pulse, even when a later beat has `wr_hold`=0.
- R6: If a channel is written with `wr_hold`=0, the live register takes the data of that same beat and the channel is no longer pending afterwards.
- R7: `out_upd[i]` is high for exactly the one cycle after the edge that loaded live register i, and is low at all other times.
- R8: The mode of channel i is decoded from bits 15:14 of its live word, and `out_mode[4*i+3:4*i]` is one-hot: 00 gives bit 0 (normal), 01 gives bit 1 (off, 1 kΩ to ground), 10 gives bit 2 (off, 100 kΩ to ground), and 11 gives bit 3 (off, high impedance).
- R9: Writing three channels with `wr_hold`=1 and then the fourth with `wr_hold`=0 makes all four live words update, and all four pulses fire, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Bank accepts a beat at this edge |
| wr_chan | input | 2 | Target channel of the beat |
| wr_data | input | 16 | Word for the staging register; bits 15:14 are the mode code |
| wr_hold | input | 1 | 1: stage only; 0: release all pending channels |
| out_word | output | 64 | Live words, channel i at bits 16*i+15:16*i |
| out_upd | output | 4 | One-cycle pulse per channel on a live load |
| out_mode | output | 16 | One-hot drive mode per channel, 4 bits each |

## Verification
The hardest case to reach is a channel that was staged long ago, then copied, and then left untouched while other channels are released with `wr_hold`=0. Such a channel must stay silent. Catching a stray reload needs a history in which the pending flags of different channels disagree. The stimulus builds that history with directed steps: a staged channel is rewritten before release, and a second release follows straight after the first. A long random phase then mixes hold values, channels, idle cycles and mode codes. A behavioural model compares every output on every clock.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

  // Drive mode carried in the top two bits of each live word
  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_OFF_1K = 2'b01,
    PD_OFF_100K = 2'b10,
    PD_OFF_HIZ = 2'b11
  } pd_code_e;

  localparam int unsigned MODE_W = 4;

endpackage

// File: rtl/dbuf_update_ctl.sv
module dbuf_update_ctl #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic              wr_hold,
  output logic              wr_ready,
  output logic [NUM_CH-1:0] wr_sel,
  output logic              xfer_req
);

  logic ready_q;
  logic accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else ready_q <= 1'b1;
  end

  assign wr_ready = ready_q;
  assign accept = wr_valid & ready_q;
  assign xfer_req = accept & ~wr_hold;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign wr_sel[g] = accept && (wr_chan == CH_W'(g));
  end

  AST_READY_STAYS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready); // R2

endmodule

// File: rtl/dbuf_channel.sv
module dbuf_channel #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              xfer_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] live_word,
  output logic              upd_pulse
);

  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] live_q;
  logic              pend_q;
  logic              upd_q;
  logic              xfer;
  logic [DATA_W-1:0] live_d;

  // Copy only when released and there is something new to pass on
  assign xfer = xfer_req & (pend_q | wr_sel);
  assign live_d = wr_sel ? wr_data : stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      live_q <= '0;
      pend_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (wr_sel) stage_q <= wr_data;
      if (xfer) live_q <= live_d;
      pend_q <= xfer ? 1'b0 : (pend_q | wr_sel);
      upd_q <= xfer;
    end
  end

  assign live_word = live_q;
  assign upd_pulse = upd_q;

  AST_STAGE_MARKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !xfer_req) |=> (pend_q && $stable(live_q))); // R3

  AST_CLEAN_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !wr_sel) |=> (!upd_q && $stable(live_q))); // R5

  AST_SAME_BEAT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && xfer_req) |=> (!pend_q && upd_q && live_q == $past(wr_data))); // R6

endmodule

// File: rtl/dbuf_mode_dec.sv
module dbuf_mode_dec
  import dbuf_pkg::*;
(
  input  logic [1:0]        code,
  output logic [MODE_W-1:0] mode
);

  always_comb begin
    unique case (pd_code_e'(code))
      PD_NORMAL:   mode = 4'b0001;
      PD_OFF_1K:   mode = 4'b0010;
      PD_OFF_100K: mode = 4'b0100;
      PD_OFF_HIZ:  mode = 4'b1000;
      default:     mode = 4'b0001;
    endcase
  end

endmodule

// File: rtl/dbuf_bank.sv
module dbuf_bank
  import dbuf_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [CH_W-1:0]          wr_chan,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_hold,
  output logic [NUM_CH*DATA_W-1:0] out_word,
  output logic [NUM_CH-1:0]        out_upd,
  output logic [NUM_CH*MODE_W-1:0] out_mode
);

  localparam int unsigned CODE_LSB = DATA_W - 2;

  logic [NUM_CH-1:0] wr_sel;
  logic              xfer_req;

  dbuf_update_ctl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
    .wr_hold(wr_hold), .wr_ready(wr_ready), .wr_sel(wr_sel), .xfer_req(xfer_req)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DATA_W-1:0] word_i;

    dbuf_channel #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel[i]), .xfer_req(xfer_req),
      .wr_data(wr_data), .live_word(word_i), .upd_pulse(out_upd[i])
    );

    dbuf_mode_dec u_dec (
      .code(word_i[CODE_LSB +: 2]),
      .mode(out_mode[MODE_W*i +: MODE_W])
    );

    assign out_word[DATA_W*i +: DATA_W] = word_i;

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(out_mode[MODE_W*i +: MODE_W])); // R8
  end

  AST_HOLD_KEEPS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_hold) |=> ($stable(out_word) && out_upd == '0)); // R3

  AST_RELEASE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_hold && (32'(wr_chan) < NUM_CH)) |=> (out_upd != '0)); // R4

endmodule

// File: tb/dbuf_bank_test.sv
`timescale 1ns/1ps
module dbuf_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_chan = '0;
  logic [15:0] wr_data = '0;
  logic        wr_hold = 1'b1;
  logic [63:0] out_word;
  logic [3:0]  out_upd;
  logic [15:0] out_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] m_in [4];
  logic [15:0] m_out [4];
  bit          m_pend [4];
  logic [3:0]  m_upd;
  bit          m_ready;

  always #2 clk = ~clk;

  dbuf_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_data(wr_data), .wr_hold(wr_hold),
    .out_word(out_word), .out_upd(out_upd), .out_mode(out_mode)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all(input bit in_rst);
    logic [63:0] ew;
    logic [15:0] em;
    for (int k = 0; k < 4; k++) begin
      ew[16*k +: 16] = m_out[k];
      em[4*k +: 4] = 4'b0001 << m_out[k][15:14];
    end
    chk(in_rst ? "R1" : "R2", "wr_ready", 64'(wr_ready), 64'(m_ready));
    chk(in_rst ? "R1" : "R4", "out_word", out_word, ew);
    chk(in_rst ? "R1" : "R7", "out_upd", 64'(out_upd), 64'(m_upd));
    chk(in_rst ? "R1" : "R8", "out_mode", 64'(out_mode), 64'(em));
  endtask

  // drive one cycle, advance the model, compare at the next falling edge
  task automatic cyc(input bit rst, input bit v, input int c, input logic [15:0] d,
                     input bit h);
    rst_n = rst;
    wr_valid = v;
    wr_chan = c[1:0];
    wr_data = d;
    wr_hold = h;
    m_upd = '0;
    if (!rst) begin
      for (int k = 0; k < 4; k++) begin
        m_in[k] = '0; m_out[k] = '0; m_pend[k] = 0;
      end
      m_ready = 0;
    end else begin
      if (v && m_ready) begin
        m_in[c] = d;
        m_pend[c] = 1;
        if (!h) begin
          for (int k = 0; k < 4; k++) begin
            if (m_pend[k]) begin
              m_out[k] = m_in[k];
              m_pend[k] = 0;
              m_upd[k] = 1'b1;
            end
          end
        end
      end
      m_ready = 1;
    end
    @(negedge clk);
    compare_all(!rst);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset with a beat offered, which must be ignored
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 16'hFFFF, 0);
    // R2: release; the beat offered on the release edge is dropped
    cyc(1, 1, 2, 16'hC123, 0);
    chk("R2", "beat before ready ignored", out_word, 64'h0);
    cyc(1, 0, 0, 16'h0, 1);

    // R3: staging only
    cyc(1, 1, 0, 16'h1234, 1);
    chk("R3", "staged upd", 64'(out_upd), 64'h0);
    chk("R3", "staged word", out_word, 64'h0);

    // R9: three staged then fourth released
    cyc(1, 1, 1, 16'h4AAA, 1);
    cyc(1, 1, 2, 16'h8555, 1);
    cyc(1, 1, 3, 16'hC0F0, 0);
    chk("R9", "all pulse", 64'(out_upd), 64'hF);
    chk("R9", "all words", out_word, 64'hC0F0_8555_4AAA_1234);

    // R5: only the rewritten channel reloads
    cyc(1, 1, 0, 16'h0001, 0);
    chk("R5", "clean channels quiet", 64'(out_upd), 64'h1);

    // R6: restage, then release on the same channel with new data
    cyc(1, 1, 2, 16'h7777, 1);
    cyc(1, 1, 2, 16'h3333, 0);
    chk("R6", "same-beat data", 64'(out_word[47:32]), 64'h3333);
    cyc(1, 1, 1, 16'h5555, 0);
    chk("R6", "flag cleared", 64'(out_upd), 64'h2);

    // R2: idle bus with data changing has no effect
    cyc(1, 0, 3, 16'hFFFF, 0);
    chk("R2", "idle no pulse", 64'(out_upd), 64'h0);

    // random phase
    for (int i = 0; i < 400; i++)
      cyc(1, ($urandom % 4) != 0, $urandom % 4, 16'($urandom), ($urandom % 3) != 0);

    // mid-run reset and recovery
    cyc(0, 0, 0, 16'h0, 1);
    cyc(1, 0, 0, 16'h0, 1);
    for (int i = 0; i < 100; i++)
      cyc(1, 1, $urandom % 4, 16'($urandom), ($urandom % 2) != 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule